// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps every row of a 1k-row asynchronous DRAM refreshed and runs the warm-up the device needs after power is applied. Once reset is released it holds off all host traffic for a long pause. It then issues a fixed number of CAS-before-RAS refresh cycles and raises `init_done`. From then on an interval timer raises one refresh request per row period. The defaults at 100 MHz are 1560 cycles, about 15.6 µs, so 1024 rows fit in 16 ms.

Pending requests go into a small backlog. When the access sequencer reports idle, the scheduler takes the strobes and runs a CAS-before-RAS refresh. The write strobe is kept high for the whole cycle, so the device never sees a test-mode entry. When the sequencer instead reports that it is holding CAS low at the tail of a read, the scheduler runs a hidden refresh. It keeps CAS low, gives RAS a precharge gap and pulls RAS low again, and the read data stays on the bus. Refresh takes priority over new host requests but never interrupts a cycle in progress. A backlog overflow raises a sticky error flag.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, and after its release until the first refresh, `ref_ras_n` and `ref_cas_n` are 1 and `ref_own`, `init_done` and `host_gnt` are 0. `busy` is 1.
- R2: Reset is released through a two-flop synchroniser. The strobes stay inactive for PAUSE_CYC cycles after that. The first CAS fall is seen in bench cycle PAUSE_CYC+3, counting posedges with `rst_n` high from 1.
- R3: Warm-up consists of exactly INIT_REFS CAS-before-RAS cycles. Each takes T_CSR+T_RAS+T_RP+1 cycles. `init_done` rises on the following edge. `host_gnt` is 0 until then.
- R4: In a CAS-before-RAS refresh, `ref_cas_n` is low for T_CSR cycles with `ref_ras_n` high. RAS then falls and stays low for T_RAS cycles. CAS stays low during that time. `ref_we_n` is 1 whenever `ref_own` is 1.
- R5: When RAS rises after a refresh, CAS rises with it. Both stay high for at least T_RP cycles before either strobe falls again.
- R6: After `init_done`, one request is raised every REFI_CYC cycles. With the sequencer idle, the first refresh starts REFI_CYC+1 cycles after `init_done` rises. Later refreshes start REFI_CYC cycles apart.
- R7: A pending refresh does not start while `seq_idle` and `rd_tail` are both 0.
- R8: A pending refresh that meets `rd_tail`=1 runs as a hidden refresh. `ref_cas_n` goes low at once with RAS high for T_RP cycles. RAS then goes low for T_RAS cycles, and CAS stays low throughout. It starts on the edge after `rd_tail` rises.
- R9: `host_gnt` is 1 only when `host_req` and `seq_idle` are 1, `rd_tail` is 0, warm-up is done, no refresh is in progress and none is pending. It is never 1 while `busy` or `ref_own` is 1.
- R10: Up to BACKLOG_MAX missed requests are held. When the sequencer becomes idle they run back to back, one every T_CSR+T_RAS+T_RP+1 cycles.
- R11: A request that arrives while the backlog holds BACKLOG_MAX entries sets `backlog_err`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_idle | input | 1 | Access sequencer idle, strobes free |
| rd_tail | input | 1 | Sequencer holding CAS low after a read |
| host_req | input | 1 | Host wants to start an access |
| host_gnt | output | 1 | Host may start an access this cycle |
| ref_own | output | 1 | Scheduler drives the strobes |
| ref_ras_n | output | 1 | Row strobe, active low |
| ref_cas_n | output | 1 | Column strobe, active low |
| ref_we_n | output | 1 | Write strobe, held high during refresh |
| busy | output | 1 | Warm-up, refresh running or refresh pending |
| init_done | output | 1 | Warm-up sequence complete |
| backlog_err | output | 1 | Sticky backlog overflow flag |

## Verification
A wrong state in the strobe engine shows up at the DRAM pins within one refresh. The CAS lead, the RAS low width or the precharge gap comes out a different length, and the scoreboard measures these lengths at every RAS fall. A timer or backlog counter that is off by even one shows up later. It appears as a refresh start cycle that is shifted, as a wrong number of back-to-back refreshes, or as a missing or early error flag. These are seen within one to five refresh intervals. Grant leakage is caught in the first cycle it happens, because every `host_gnt` pulse is checked against `busy` and `ref_own`.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSR,
    ST_ACT,
    ST_PRE,
    ST_HPRE,
    ST_HACT
  } eng_state_t;
endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
  parameter int PAUSE_CYC = 20000,
  parameter int REFI_CYC  = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pause_done,
  output logic tick
);
  localparam int PW = $clog2(PAUSE_CYC);
  localparam int IW = $clog2(REFI_CYC);

  logic [PW-1:0] pause_q, pause_d;
  logic          pdone_q, pdone_d;
  logic [IW-1:0] ivl_q, ivl_d;

  always_comb begin
    pause_d = pause_q;
    pdone_d = pdone_q;
    if (!pdone_q) begin
      if (pause_q == PW'(PAUSE_CYC - 1)) pdone_d = 1'b1;
      else                               pause_d = pause_q + 1'b1;
    end
  end

  assign tick = run && (ivl_q == IW'(REFI_CYC - 1));

  always_comb begin
    ivl_d = ivl_q;
    if (run) ivl_d = tick ? '0 : ivl_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_q <= '0;
      pdone_q <= 1'b0;
      ivl_q   <= '0;
    end else begin
      pause_q <= pause_d;
      pdone_q <= pdone_d;
      ivl_q   <= ivl_d;
    end
  end

  assign pause_done = pdone_q;

  AST_NO_TICK_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> pause_done); // R6
endmodule

// File: rtl/refsched_backlog.sv
module refsched_backlog #(
  parameter int BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic pending_nz,
  output logic err
);
  localparam int CW = $clog2(BACKLOG_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          full;

  assign full = (cnt_q == CW'(BACKLOG_MAX));

  always_comb begin
    cnt_d = cnt_q;
    err_d = err_q;
    if (inc && !dec) begin
      if (full) err_d = 1'b1;
      else      cnt_d = cnt_q + 1'b1;
    end else if (dec && !inc) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign pending_nz = (cnt_q != '0);
  assign err        = err_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BACKLOG_MAX)); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> pending_nz); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R11
endmodule

// File: rtl/refsched_engine.sv
module refsched_engine
  import refsched_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_RAS = 6,
  parameter int T_RP  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_cbr,
  input  logic start_hid,
  output logic ras_n,
  output logic cas_n,
  output logic own,
  output logic idle
);
  localparam int TM1  = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int TMAX = (TM1 > T_RP) ? TM1 : T_RP;
  localparam int CW   = $clog2(TMAX + 1);

  eng_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = last ? cnt_q : cnt_q - 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (start_hid) begin
          state_d = ST_HPRE;
          cnt_d   = CW'(T_RP - 1);
        end else if (start_cbr) begin
          state_d = ST_CSR;
          cnt_d   = CW'(T_CSR - 1);
        end
      end
      ST_CSR:  if (last) begin state_d = ST_ACT;  cnt_d = CW'(T_RAS - 1); end
      ST_ACT:  if (last) begin state_d = ST_PRE;  cnt_d = CW'(T_RP - 1);  end
      ST_PRE:  if (last) begin state_d = ST_IDLE; end
      ST_HPRE: if (last) begin state_d = ST_HACT; cnt_d = CW'(T_RAS - 1); end
      ST_HACT: if (last) begin state_d = ST_PRE;  cnt_d = CW'(T_RP - 1);  end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ras_n = !((state_q == ST_ACT) || (state_q == ST_HACT));
  assign cas_n = !((state_q == ST_CSR) || (state_q == ST_ACT) ||
                   (state_q == ST_HPRE) || (state_q == ST_HACT));
  assign own   = (state_q != ST_IDLE);
  assign idle  = (state_q == ST_IDLE);

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(cas_n) == 1'b0)); // R4
  AST_CAS_HELD_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> !cas_n); // R4
  AST_PRECHARGE_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n); // R5
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cbr || start_hid) |-> idle); // R9
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PAUSE_CYC   = 20000,
  parameter int REFI_CYC    = 1560,
  parameter int INIT_REFS   = 8,
  parameter int BACKLOG_MAX = 8,
  parameter int T_CSR       = 1,
  parameter int T_RAS       = 6,
  parameter int T_RP        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_idle,
  input  logic rd_tail,
  input  logic host_req,
  output logic host_gnt,
  output logic ref_own,
  output logic ref_ras_n,
  output logic ref_cas_n,
  output logic ref_we_n,
  output logic busy,
  output logic init_done,
  output logic backlog_err
);
  localparam int NW = $clog2(INIT_REFS + 1);

  logic          rs1_q, rst_i;
  logic          pause_done, tick, pending_nz, eng_idle;
  logic          demand, start_cbr, start_hid, start_any;
  logic [NW-1:0] left_q, left_d;
  logic          done_q, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_i <= rs1_q;
    end
  end

  refsched_timer #(.PAUSE_CYC(PAUSE_CYC), .REFI_CYC(REFI_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_i), .run(done_q),
    .pause_done(pause_done), .tick(tick)
  );

  refsched_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_blg (
    .clk(clk), .rst_n(rst_i), .inc(tick), .dec(start_any && done_q),
    .pending_nz(pending_nz), .err(backlog_err)
  );

  refsched_engine #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_eng (
    .clk(clk), .rst_n(rst_i), .start_cbr(start_cbr), .start_hid(start_hid),
    .ras_n(ref_ras_n), .cas_n(ref_cas_n), .own(ref_own), .idle(eng_idle)
  );

  assign demand    = done_q ? pending_nz : (pause_done && (left_q != '0));
  assign start_hid = eng_idle && demand && done_q && rd_tail;
  assign start_cbr = eng_idle && demand && seq_idle && !start_hid;
  assign start_any = start_cbr || start_hid;

  always_comb begin
    left_d = left_q;
    done_d = done_q;
    if (!done_q && start_any) left_d = left_q - 1'b1;
    if (!done_q && pause_done && (left_q == '0) && eng_idle) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      left_q <= NW'(INIT_REFS);
      done_q <= 1'b0;
    end else begin
      left_q <= left_d;
      done_q <= done_d;
    end
  end

  assign init_done = done_q;
  assign ref_we_n  = 1'b1;
  assign busy      = !done_q || !eng_idle || pending_nz;
  assign host_gnt  = host_req && seq_idle && !rd_tail && done_q && eng_idle &&
                     !pending_nz && !tick;

  AST_GNT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_i)
    host_gnt |-> (!ref_own && !busy)); // R9
  AST_GNT_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_i)
    host_gnt |-> init_done); // R3
  AST_QUIET_DURING_PAUSE: assert property (@(posedge clk) disable iff (!rst_i)
    !pause_done |-> (ref_cas_n && ref_ras_n)); // R2
  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_i)
    init_done |=> init_done); // R3
endmodule

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
  localparam int PAUSE = 50;
  localparam int REFI  = 64;
  localparam int NINIT = 8;
  localparam int BMAX  = 4;
  localparam int TCSR  = 2;
  localparam int TRAS  = 4;
  localparam int TRP   = 3;
  localparam int SLOT  = TCSR + TRAS + TRP + 1;
  localparam int LAT   = 2;

  logic clk = 1'b0;
  logic rst_n, seq_idle, rd_tail, host_req;
  logic host_gnt, ref_own, ref_ras_n, ref_cas_n, ref_we_n, busy, init_done, backlog_err;

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .REFI_CYC(REFI), .INIT_REFS(NINIT), .BACKLOG_MAX(BMAX),
    .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle), .rd_tail(rd_tail),
    .host_req(host_req), .host_gnt(host_gnt), .ref_own(ref_own),
    .ref_ras_n(ref_ras_n), .ref_cas_n(ref_cas_n), .ref_we_n(ref_we_n),
    .busy(busy), .init_done(init_done), .backlog_err(backlog_err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  int fall_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor / scoreboard
  logic p_ras = 1'b1, p_cas = 1'b1, cas_up_in_ras = 1'b0;
  int lead = 0, ras_lo = 0, ras_hi = 100, cas_hi = 100;
  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1'b1; p_cas = 1'b1; lead = 0; ras_lo = 0; ras_hi = 100; cas_hi = 100;
    end else begin
      if (ref_own && !ref_we_n) chk(1'b0, "R4 we_n high while owned", 0, 1);
      if (host_gnt) chk(!busy && !ref_own && init_done, "R9 grant while busy", int'(busy), 0);
      if (p_cas && !ref_cas_n) begin
        fall_q.push_back(cyc);
        chk(ref_ras_n == 1'b1, "R4 cas falls before ras", int'(ref_ras_n), 1);
        chk(cas_hi >= TRP, "R5 cas precharge", cas_hi, TRP);
      end
      if (p_ras && !ref_ras_n) begin
        chk(ref_cas_n == 1'b0, "R4 cas low at ras fall", int'(ref_cas_n), 0);
        chk(ras_hi >= TRP, "R5 ras precharge", ras_hi, TRP);
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected refresh", lead, -1);
        else begin
          automatic int e = exp_q.pop_front();
          chk(lead == e, (e == TRP) ? "R8 hidden lead" : "R4 cbr lead", lead, e);
        end
        cas_up_in_ras = 1'b0;
      end
      if (!p_ras && ref_ras_n) begin
        chk(ras_lo == TRAS, "R4 ras low width", ras_lo, TRAS);
        chk(!cas_up_in_ras, "R4 cas held during ras", 1, 0);
        chk(ref_cas_n == 1'b1, "R5 cas rises with ras", int'(ref_cas_n), 1);
      end
      if (!ref_ras_n && ref_cas_n) cas_up_in_ras = 1'b1;
      lead   = (!ref_cas_n && ref_ras_n) ? lead + 1 : 0;
      ras_lo = !ref_ras_n ? ras_lo + 1 : 0;
      ras_hi = ref_ras_n ? ras_hi + 1 : 0;
      cas_hi = ref_cas_n ? cas_hi + 1 : 0;
      p_ras = ref_ras_n;
      p_cas = ref_cas_n;
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
    #1;
  endtask

  task automatic wait_falls(input int n);
    while (fall_q.size() < n) begin @(negedge clk); #1; end
  endtask

  task automatic push_exp(input int n, input int ld);
    for (int i = 0; i < n; i++) exp_q.push_back(ld);
  endtask

  bit finished = 1'b0;

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    int f, fp;
    rst_n = 1'b0; seq_idle = 1'b1; rd_tail = 1'b0; host_req = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(ref_ras_n && ref_cas_n, "R1 strobes idle in reset", int'(ref_cas_n), 1);
    chk(!ref_own && !init_done && !host_gnt, "R1 flags low in reset", int'(ref_own), 0);
    chk(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
    rst_n = 1'b1;
    push_exp(NINIT, TCSR);
    wait_cyc(1);
    chk(ref_ras_n && ref_cas_n && !host_gnt, "R1 idle after release", int'(ref_cas_n), 1);
    wait_cyc(PAUSE + LAT);
    chk(fall_q.size() == 0, "R2 quiet during pause", fall_q.size(), 0);
    wait_cyc(PAUSE + LAT + NINIT * SLOT);
    chk(init_done == 1'b0, "R3 init_done not early", int'(init_done), 0);
    wait_cyc(PAUSE + LAT + 1 + NINIT * SLOT);
    chk(init_done == 1'b1, "R3 init_done rises", int'(init_done), 1);
    chk(fall_q.size() == NINIT, "R3 warm-up count", fall_q.size(), NINIT);
    chk(fall_q[0] == PAUSE + LAT + 1, "R2 first refresh cycle", fall_q[0], PAUSE + LAT + 1);
    fall_q.delete();
    wait_cyc(PAUSE + LAT + 8 + NINIT * SLOT);
    chk(host_gnt == 1'b1, "R9 grant when quiet", int'(host_gnt), 1);
    chk(busy == 1'b0, "R9 not busy when quiet", int'(busy), 0);

    push_exp(2, TCSR);
    wait_falls(2);
    chk(fall_q[0] == PAUSE + LAT + 2 + NINIT * SLOT + REFI, "R6 first periodic",
        fall_q[0], PAUSE + LAT + 2 + NINIT * SLOT + REFI);
    chk(fall_q[1] - fall_q[0] == REFI, "R6 interval", fall_q[1] - fall_q[0], REFI);
    f = fall_q[1];
    fall_q.delete();
    seq_idle = 1'b0;
    wait_cyc(f + 3 * REFI);
    chk(fall_q.size() == 0, "R7 no refresh while not idle", fall_q.size(), 0);
    chk(busy == 1'b1, "R10 busy with backlog", int'(busy), 1);
    chk(host_gnt == 1'b0, "R9 no grant with backlog", int'(host_gnt), 0);
    push_exp(3, TCSR);
    seq_idle = 1'b1;
    wait_falls(3);
    chk(fall_q[0] == f + 3 * REFI + 1, "R10 backlog drain start", fall_q[0], f + 3 * REFI + 1);
    chk(fall_q[1] - fall_q[0] == SLOT, "R10 back to back", fall_q[1] - fall_q[0], SLOT);
    chk(fall_q[2] - fall_q[1] == SLOT, "R10 back to back", fall_q[2] - fall_q[1], SLOT);
    fall_q.delete();

    push_exp(1, TCSR);
    wait_falls(1);
    fp = fall_q[0];
    chk(fp == f + 4 * REFI, "R6 period after backlog", fp, f + 4 * REFI);
    fall_q.delete();
    seq_idle = 1'b0;
    push_exp(1, TRP);
    wait_cyc(fp + REFI + 6);
    chk(fall_q.size() == 0, "R7 pending waits", fall_q.size(), 0);
    rd_tail = 1'b1;
    wait_falls(1);
    chk(fall_q[0] == fp + REFI + 7, "R8 hidden start", fall_q[0], fp + REFI + 7);
    chk(ref_ras_n == 1'b1, "R8 ras high in hidden precharge", int'(ref_ras_n), 1);
    rd_tail = 1'b0;
    fall_q.delete();

    wait_cyc(fp + 6 * REFI - 4);
    chk(backlog_err == 1'b0, "R11 no error at full", int'(backlog_err), 0);
    wait_cyc(fp + 6 * REFI + 6);
    chk(backlog_err == 1'b1, "R11 overflow flagged", int'(backlog_err), 1);
    push_exp(BMAX, TCSR);
    seq_idle = 1'b1;
    wait_falls(BMAX);
    for (int i = 1; i < BMAX; i++)
      chk(fall_q[i] - fall_q[i-1] == SLOT, "R10 drain spacing", fall_q[i] - fall_q[i-1], SLOT);
    wait_cyc(fall_q[BMAX-1] + SLOT + 2);
    chk(backlog_err == 1'b1, "R11 error sticky", int'(backlog_err), 1);
    chk(busy == 1'b0, "R10 drained", int'(busy), 0);
    chk(exp_q.size() == 0, "R4 all expected refreshes seen", exp_q.size(), 0);
    summary();
  end
endmodule